// File: doc/BRIEF.md
# Multiplexed External Bus Demultiplexer

This block connects a 16-bit multiplexed address/data bus to two byte-wide asynchronous SRAMs. While reset is held it reads three strap pins and chooses one of three operating modes. In single-chip mode no memory cycles are issued. In wide mode the two 8-bit ports carry the high and low halves of both address and data. In narrow mode the high port time-shares the upper address byte with the single data byte, and the low port carries only the lower address byte.

The bus phase input splits every bus cycle into two halves. While it is low (address phase), the block keeps capturing the address and the access controls from the pins. While it is high (data phase), the block holds the last captured values and drives the memory strobes. The byte-strobe, address bit 0 and read/not-write controls decide which byte lanes are enabled. Illegal combinations are suppressed and recorded in a sticky error flag. A window select input decides how the physical address is formed. It is either a page register value placed above the low 14 address bits, or the full 16-bit address zero-extended. In narrow mode, a 16-bit request is carried out as two byte cycles over two consecutive bus cycles.

Top module: `mux_bus_demux`

## Requirements
- R1: The mode is set only from the strap pins seen during reset (strap_dbg, strap_hi, strap_lo). The encodings are 1,1,1 for wide, 1,0,1 for narrow and 1,0,0 for single-chip, and every other combination also gives single-chip. Changing the straps after reset has no effect.
- R2: In single-chip mode no chip select, output enable or write enable is asserted, and neither mem_dq_oe nor port_oe_o is set, whatever the bus inputs are doing.
- R3: The address, controls, page bits and window select are captured while bphase is low. They are held unchanged while bphase is high, even if the pins change.
- R4: With win_n low, phys_addr_o = {page, addr[13:0]}. With win_n high, phys_addr_o = {4'b0, addr[15:0]}.
- R5: Lane vectors use bit 1 for the high lane (D15..D8, even byte) and bit 0 for the low lane (D7..D0, odd byte). In the data phase, with {lo_sel_n, A0}: 1,0 enables the high lane only, 0,1 enables the low lane only, and 0,0 enables both. Reads (rnw=1) pull mem_oe_n low on the enabled lanes, and writes pull mem_we_n low on them. mem_cs_n is low exactly on the enabled lanes.
- R6: The combination lo_sel_n=1 with A0=1 asserts no memory strobe and sets bus_err_o in that data phase. bus_err_o then stays set until reset.
- R7: mem_dq_oe is set only on the enabled lanes of a write data phase and is zero in every address phase. In wide mode the high port drives mem_dq_o[15:8] and the low port drives mem_dq_o[7:0].
- R8: In wide mode, a read sets port_oe_o on the enabled lanes and returns mem_dq_i[15:8] on port_hi_o and mem_dq_i[7:0] on port_lo_o.
- R9: In narrow mode all data moves on the high port. Write data from port_hi_i goes to whichever lane is enabled. A read sets only port_oe_o[1] and returns the enabled lane's byte on port_hi_o.
- R10: In narrow mode a 16-bit request (lo_sel_n=0, A0=0) uses the high lane in its own data phase. The next bus cycle then becomes a low-lane access at the same address with bit 0 set. The pins in that cycle's address phase are ignored, and normal capture resumes after it.
- R11: rst_n is active low and synchronous. While it is low the block is in single-chip mode with all strobes high and bus_err_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_dbg | input | 1 | Mode strap, must be 1 for expanded modes |
| strap_hi | input | 1 | Mode strap, upper select |
| strap_lo | input | 1 | Mode strap, lower select |
| bphase | input | 1 | Bus phase: 0 address, 1 data |
| lo_sel_n | input | 1 | Active-low low-byte strobe |
| rnw | input | 1 | 1 read, 0 write |
| win_n | input | 1 | Page window select, low selects paged address |
| page_i | input | PAGE_W | Page bits |
| port_hi_i | input | 8 | High multiplexed port in |
| port_lo_i | input | 8 | Low multiplexed port in |
| port_hi_o | output | 8 | High port read data |
| port_lo_o | output | 8 | Low port read data |
| port_oe_o | output | 2 | Port drive enables {high, low} |
| phys_addr_o | output | PAGE_W+WIN_W | Physical memory address |
| mem_cs_n | output | 2 | Chip selects {high, low}, active low |
| mem_oe_n | output | 2 | Output enables, active low |
| mem_we_n | output | 2 | Write enables, active low |
| mem_dq_o | output | 16 | Write data to memories |
| mem_dq_oe | output | 2 | Memory data drive enables per lane |
| mem_dq_i | input | 16 | Read data from memories |
| bus_err_o | output | 1 | Sticky illegal-access flag |

## Verification
The bench drives the port pins with data and flips the page and window inputs during the data phase. A design whose latch follows the pins would then move phys_addr_o. It runs both illegal strobe cases and a later legal cycle. A design that lets either illegal case through would pulse a chip select, and one that clears the flag would drop bus_err_o early. It walks the narrow 16-bit split with deliberately illegal pins in the second address phase. A design that recaptured those pins would show the wrong address and raise the error flag. It also changes the straps after reset, which catches a design that keeps sampling them.

// File: rtl/mux_bus_demux.sv
module mux_bus_demux #(
  parameter int PAGE_W = 6,
  parameter int WIN_W  = 14,
  localparam int XAW   = PAGE_W + WIN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_dbg,
  input  logic              strap_hi,
  input  logic              strap_lo,
  input  logic              bphase,
  input  logic              lo_sel_n,
  input  logic              rnw,
  input  logic              win_n,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [7:0]        port_hi_i,
  input  logic [7:0]        port_lo_i,
  output logic [7:0]        port_hi_o,
  output logic [7:0]        port_lo_o,
  output logic [1:0]        port_oe_o,
  output logic [XAW-1:0]    phys_addr_o,
  output logic [1:0]        mem_cs_n,
  output logic [1:0]        mem_oe_n,
  output logic [1:0]        mem_we_n,
  output logic [15:0]       mem_dq_o,
  output logic [1:0]        mem_dq_oe,
  input  logic [15:0]       mem_dq_i,
  output logic              bus_err_o
);

  typedef enum logic [1:0] {M_SINGLE, M_WIDE, M_NARROW} mode_t;

  function automatic mode_t strap_mode(input logic d, input logic h, input logic l);
    if (d && h && l)        return M_WIDE;
    else if (d && !h && l)  return M_NARROW;
    else                    return M_SINGLE;
  endfunction

  mode_t              mode_q, strap_q;
  logic               live_q, eclk_d, second_q, err_q;
  logic [15:0]        addr_q;
  logic               losel_q, rnw_q, win_q;
  logic [PAGE_W-1:0]  page_q;
  logic               expanded, narrow, is16, illegal, phase_end, split_start, latch_en, active;
  logic [1:0]         lane, lane_on, rd_lanes;
  logic [15:0]        eff_addr;

  assign expanded    = (mode_q == M_WIDE) || (mode_q == M_NARROW);
  assign narrow      = (mode_q == M_NARROW);
  assign is16        = !losel_q && !addr_q[0];
  assign illegal     = losel_q && addr_q[0] && !second_q;
  assign phase_end   = expanded && !bphase && eclk_d;
  assign split_start = phase_end && narrow && is16 && !second_q;
  assign latch_en    = expanded && !bphase && !second_q && !split_start;
  assign active      = expanded && bphase && !illegal;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= M_SINGLE;
      strap_q  <= strap_mode(strap_dbg, strap_hi, strap_lo);
      live_q   <= 1'b0;
      eclk_d   <= 1'b0;
      second_q <= 1'b0;
      err_q    <= 1'b0;
      addr_q   <= '0;
      losel_q  <= 1'b1;
      rnw_q    <= 1'b1;
      win_q    <= 1'b1;
      page_q   <= '0;
    end else begin
      if (!live_q) begin
        mode_q <= strap_q;
        live_q <= 1'b1;
      end
      eclk_d <= bphase;
      if (latch_en) begin
        addr_q  <= {port_hi_i, port_lo_i};
        losel_q <= lo_sel_n;
        rnw_q   <= rnw;
        win_q   <= win_n;
        page_q  <= page_i;
      end
      if (phase_end) second_q <= split_start;
      if (expanded && bphase && illegal) err_q <= 1'b1;
    end
  end

  always_comb begin
    if (second_q) lane = 2'b01;
    else begin
      case ({losel_q, addr_q[0]})
        2'b10:   lane = 2'b10;
        2'b01:   lane = 2'b01;
        2'b00:   lane = narrow ? 2'b10 : 2'b11;
        default: lane = 2'b00;
      endcase
    end
  end

  assign lane_on   = active ? lane : 2'b00;
  assign rd_lanes  = lane_on & {2{rnw_q}};
  assign mem_cs_n  = ~lane_on;
  assign mem_oe_n  = ~rd_lanes;
  assign mem_we_n  = ~(lane_on & {2{~rnw_q}});
  assign mem_dq_oe = lane_on & {2{~rnw_q}};
  assign mem_dq_o  = narrow ? {port_hi_i, port_hi_i} : {port_hi_i, port_lo_i};
  assign port_oe_o = narrow ? {|rd_lanes, 1'b0} : rd_lanes;
  assign port_hi_o = (narrow && rd_lanes[0]) ? mem_dq_i[7:0] : mem_dq_i[15:8];
  assign port_lo_o = mem_dq_i[7:0];
  assign bus_err_o = err_q;

  assign eff_addr    = second_q ? (addr_q | 16'h0001) : addr_q;
  assign phys_addr_o = win_q ? {{(XAW-16){1'b0}}, eff_addr}
                             : {page_q, eff_addr[WIN_W-1:0]};

  // R1
  mode_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && $past(live_q) |-> $stable(mode_q));
  // R2
  single_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_SINGLE) |-> (mem_cs_n == 2'b11 && mem_dq_oe == 2'b00 && port_oe_o == 2'b00));
  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bphase && $past(bphase) |-> $stable(phys_addr_o));
  // R5
  rw_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~mem_oe_n) & (~mem_we_n)) == 2'b00);
  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err_o |=> bus_err_o);
  // R7
  addr_phase_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bphase |-> (mem_dq_oe == 2'b00 && mem_cs_n == 2'b11));

endmodule

// File: tb/mux_bus_demux_tb.sv
module mux_bus_demux_tb;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic strap_dbg = 1'b0, strap_hi = 1'b0, strap_lo = 1'b0;
  logic bphase = 1'b0, lo_sel_n = 1'b1, rnw = 1'b1, win_n = 1'b1;
  logic [5:0]  page_i = '0;
  logic [7:0]  port_hi_i = '0, port_lo_i = '0;
  logic [15:0] mem_dq_i = '0;
  logic [7:0]  port_hi_o, port_lo_o;
  logic [1:0]  port_oe_o, mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [19:0] phys_addr_o;
  logic [15:0] mem_dq_o;
  logic        bus_err_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [1:0]  s_cs, s_oe, s_we, s_dqoe, s_poe, a_cs, a_dqoe;
  logic [15:0] s_dqo;
  logic [7:0]  s_phi, s_plo;
  logic [19:0] s_pa;

  always #(CLK_P/2) clk = ~clk;

  mux_bus_demux u_dut (
    .clk(clk), .rst_n(rst_n), .strap_dbg(strap_dbg), .strap_hi(strap_hi), .strap_lo(strap_lo),
    .bphase(bphase), .lo_sel_n(lo_sel_n), .rnw(rnw), .win_n(win_n), .page_i(page_i),
    .port_hi_i(port_hi_i), .port_lo_i(port_lo_i), .port_hi_o(port_hi_o), .port_lo_o(port_lo_o),
    .port_oe_o(port_oe_o), .phys_addr_o(phys_addr_o), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i),
    .bus_err_o(bus_err_o));

  typedef struct packed {
    logic [1:0]  md;
    logic [15:0] a;
    logic        ls, rw, win;
    logic [5:0]  pg;
    logic [15:0] wd, rd;
    logic [1:0]  cs, oe, we, dqoe;
    logic [19:0] xa;
  } vec_t;

  // md: 1 wide, 2 narrow
  localparam vec_t VT [12] = '{
    '{2'd1, 16'h1234, 1'b1, 1'b1, 1'b1, 6'h00, 16'hA55A, 16'hC33C, 2'b01, 2'b01, 2'b11, 2'b00, 20'h01234}, // R5 even read
    '{2'd1, 16'h1235, 1'b0, 1'b1, 1'b1, 6'h00, 16'hA55A, 16'h7E81, 2'b10, 2'b10, 2'b11, 2'b00, 20'h01235}, // R5 odd read
    '{2'd1, 16'h2000, 1'b1, 1'b0, 1'b1, 6'h00, 16'hBEEF, 16'h0000, 2'b01, 2'b11, 2'b01, 2'b10, 20'h02000}, // R7 even write
    '{2'd1, 16'h2001, 1'b0, 1'b0, 1'b1, 6'h00, 16'h1357, 16'h0000, 2'b10, 2'b11, 2'b10, 2'b01, 20'h02001}, // R7 odd write
    '{2'd1, 16'h4000, 1'b0, 1'b1, 1'b1, 6'h00, 16'h0000, 16'h9ABC, 2'b00, 2'b00, 2'b11, 2'b00, 20'h04000}, // R8 word read
    '{2'd1, 16'h4002, 1'b0, 1'b0, 1'b0, 6'h3F, 16'hCAFE, 16'h0000, 2'b00, 2'b11, 2'b00, 2'b11, 20'hFC002}, // R4 paged word write
    '{2'd1, 16'hBFFF, 1'b0, 1'b1, 1'b0, 6'h15, 16'h0000, 16'h5AA5, 2'b10, 2'b10, 2'b11, 2'b00, 20'h57FFF}, // R4 paged odd read
    '{2'd1, 16'h1111, 1'b1, 1'b1, 1'b1, 6'h00, 16'h0000, 16'hFFFF, 2'b11, 2'b11, 2'b11, 2'b00, 20'h01111}, // R6 illegal read
    '{2'd1, 16'h3333, 1'b1, 1'b0, 1'b1, 6'h00, 16'h2468, 16'h0000, 2'b11, 2'b11, 2'b11, 2'b00, 20'h03333}, // R6 illegal write
    '{2'd2, 16'h0400, 1'b1, 1'b0, 1'b1, 6'h00, 16'h6D00, 16'h0000, 2'b01, 2'b11, 2'b01, 2'b10, 20'h00400}, // R9 narrow even write
    '{2'd2, 16'h0401, 1'b0, 1'b1, 1'b1, 6'h00, 16'h0000, 16'h12F0, 2'b10, 2'b10, 2'b11, 2'b00, 20'h00401}, // R9 narrow odd read
    '{2'd2, 16'h0600, 1'b0, 1'b1, 1'b1, 6'h00, 16'h0000, 16'h8844, 2'b01, 2'b01, 2'b11, 2'b00, 20'h00600}  // R10 narrow word, first half
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic d, input logic h, input logic l);
    rst_n = 1'b0; strap_dbg = d; strap_hi = h; strap_lo = l; bphase = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    {strap_dbg, strap_hi, strap_lo} = ~{d, h, l};
    repeat (2) @(negedge clk);
  endtask

  task automatic bus_cycle(input logic [15:0] a, input logic ls, input logic rw_v, input logic wv,
                           input logic [5:0] pg, input logic [15:0] wd, input logic [15:0] rd);
    bphase = 1'b0; {port_hi_i, port_lo_i} = a; lo_sel_n = ls; rnw = rw_v; win_n = wv; page_i = pg;
    repeat (2) @(posedge clk);
    #2; a_cs = mem_cs_n; a_dqoe = mem_dq_oe;
    @(negedge clk);
    bphase = 1'b1; {port_hi_i, port_lo_i} = wd; mem_dq_i = rd;
    page_i = ~pg; win_n = ~wv; lo_sel_n = ~ls; rnw = ~rw_v;
    @(posedge clk);
    #2;
    s_cs = mem_cs_n; s_oe = mem_oe_n; s_we = mem_we_n; s_dqoe = mem_dq_oe; s_dqo = mem_dq_o;
    s_phi = port_hi_o; s_plo = port_lo_o; s_poe = port_oe_o; s_pa = phys_addr_o;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(negedge clk);
    // R11: reset state with expanded straps and an active data phase
    rst_n = 1'b0; strap_dbg = 1'b1; strap_hi = 1'b1; strap_lo = 1'b1;
    bphase = 1'b1; lo_sel_n = 1'b0; rnw = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 cs_n in reset", 32'(mem_cs_n), 32'h3);
    chk("R11 we_n in reset", 32'(mem_we_n), 32'h3);
    chk("R11 dq_oe in reset", 32'(mem_dq_oe), 32'h0);
    chk("R11 err in reset", 32'(bus_err_o), 32'h0);

    for (int i = 0; i < 12; i++) begin
      vec_t v;
      logic [1:0] rdl, wrl;
      v = VT[i];
      if (v.md == 2'd1) do_reset(1'b1, 1'b1, 1'b1);
      else              do_reset(1'b1, 1'b0, 1'b1);
      bus_cycle(v.a, v.ls, v.rw, v.win, v.pg, v.wd, v.rd);
      rdl = ~v.oe; wrl = ~v.we;
      chk($sformatf("R5 cs_n vec%0d", i), 32'(s_cs), 32'(v.cs));
      chk($sformatf("R5 oe_n vec%0d", i), 32'(s_oe), 32'(v.oe));
      chk($sformatf("R5 we_n vec%0d", i), 32'(s_we), 32'(v.we));
      chk($sformatf("R7 dq_oe vec%0d", i), 32'(s_dqoe), 32'(v.dqoe));
      chk($sformatf("R4/R3 addr vec%0d", i), 32'(s_pa), 32'(v.xa));
      chk($sformatf("R7 addr-phase cs vec%0d", i), 32'(a_cs), 32'h3);
      chk($sformatf("R7 addr-phase dq_oe vec%0d", i), 32'(a_dqoe), 32'h0);
      chk($sformatf("R6 err vec%0d", i), 32'(bus_err_o), 32'(v.cs == 2'b11));
      if (v.md == 2'd1) begin
        if (wrl[1]) chk($sformatf("R7 wdata hi vec%0d", i), 32'(s_dqo[15:8]), 32'(v.wd[15:8]));
        if (wrl[0]) chk($sformatf("R7 wdata lo vec%0d", i), 32'(s_dqo[7:0]), 32'(v.wd[7:0]));
        chk($sformatf("R8 port_oe vec%0d", i), 32'(s_poe), 32'(rdl));
        if (rdl[1]) chk($sformatf("R8 rdata hi vec%0d", i), 32'(s_phi), 32'(v.rd[15:8]));
        if (rdl[0]) chk($sformatf("R8 rdata lo vec%0d", i), 32'(s_plo), 32'(v.rd[7:0]));
      end else begin
        if (wrl[1]) chk($sformatf("R9 wdata hi vec%0d", i), 32'(s_dqo[15:8]), 32'(v.wd[15:8]));
        if (wrl[0]) chk($sformatf("R9 wdata lo vec%0d", i), 32'(s_dqo[7:0]), 32'(v.wd[15:8]));
        chk($sformatf("R9 port_oe vec%0d", i), 32'(s_poe), 32'({|rdl, 1'b0}));
        if (rdl[1]) chk($sformatf("R9 rdata even vec%0d", i), 32'(s_phi), 32'(v.rd[15:8]));
        if (rdl[0]) chk($sformatf("R9 rdata odd vec%0d", i), 32'(s_phi), 32'(v.rd[7:0]));
      end
    end

    // R2, R1: single-chip straps give no memory activity
    do_reset(1'b1, 1'b0, 1'b0);
    bus_cycle(16'h4000, 1'b0, 1'b0, 1'b1, 6'h00, 16'h1111, 16'h2222);
    chk("R2 cs_n single", 32'(s_cs), 32'h3);
    chk("R2 we_n single", 32'(s_we), 32'h3);
    chk("R2 dq_oe single", 32'(s_dqoe), 32'h0);
    chk("R2 port_oe single", 32'(s_poe), 32'h0);
    do_reset(1'b0, 1'b1, 1'b1);
    bus_cycle(16'h4000, 1'b0, 1'b1, 1'b1, 6'h00, 16'h0, 16'h2222);
    chk("R1 other strap code is single", 32'(s_cs), 32'h3);

    // R1: wide straps, then pins switched to narrow code after reset
    do_reset(1'b1, 1'b1, 1'b1);
    strap_dbg = 1'b1; strap_hi = 1'b0; strap_lo = 1'b1;
    bus_cycle(16'h4000, 1'b0, 1'b1, 1'b1, 6'h00, 16'h0, 16'h3344);
    chk("R1 straps ignored after reset", 32'(s_cs), 32'h0);

    // R6: error stays set across a legal cycle, cleared by reset
    do_reset(1'b1, 1'b1, 1'b1);
    bus_cycle(16'h0001, 1'b1, 1'b1, 1'b1, 6'h00, 16'h0, 16'h0);
    bus_cycle(16'h0002, 1'b1, 1'b1, 1'b1, 6'h00, 16'h0, 16'h0);
    chk("R6 legal cycle after error", 32'(s_cs), 32'h1);
    chk("R6 err sticky", 32'(bus_err_o), 32'h1);
    do_reset(1'b1, 1'b1, 1'b1);
    chk("R6 err cleared by reset", 32'(bus_err_o), 32'h0);

    // R10: narrow word write split, second address phase pins ignored
    do_reset(1'b1, 1'b0, 1'b1);
    bus_cycle(16'h0800, 1'b0, 1'b0, 1'b1, 6'h00, 16'hA100, 16'h0);
    chk("R10 first half we_n", 32'(s_we), 32'h1);
    chk("R10 first half addr", 32'(s_pa), 32'h00800);
    chk("R10 first half data", 32'(s_dqo[15:8]), 32'hA1);
    bus_cycle(16'hFFFF, 1'b1, 1'b1, 1'b1, 6'h00, 16'hB200, 16'h0);
    chk("R10 second half we_n", 32'(s_we), 32'h2);
    chk("R10 second half dq_oe", 32'(s_dqoe), 32'h1);
    chk("R10 second half addr", 32'(s_pa), 32'h00801);
    chk("R10 second half data", 32'(s_dqo[7:0]), 32'hB2);
    chk("R10 no error from ignored pins", 32'(bus_err_o), 32'h0);
    bus_cycle(16'h0900, 1'b1, 1'b1, 1'b1, 6'h00, 16'h0, 16'h7788);
    chk("R10 capture resumes addr", 32'(s_pa), 32'h00900);
    chk("R10 capture resumes cs_n", 32'(s_cs), 32'h1);

    finish_run();
  end
endmodule